// File: doc/BRIEF.md
# Configurable Programmable-Logic I/O Cell

This block models one programmable I/O cell of a logic fabric. A static configuration word shapes it. On the output side, a two-input output stage feeds the pad. The stage either shares the pad between two internal signals through a 2:1 selector, or acts as a small gate: pass, AND, OR or XOR, with either input optionally inverted. The pad value comes straight from that stage or from an output register.

On the input side, pad data is captured either in an edge-triggered register or in a transparent latch. The output register and the input capture element each have their own clock and their own edge or level polarity. They share an active-high clock enable. An asynchronous global set/reset forces each storage element to its own configured value.

An active-low three-state control decides whether the pad is driven. While the pad is not driven, a pad-observe output shows the modelled default pull level. Each data path is `W` lanes wide, and every lane uses the same configuration.

Top module: `pio_cell`

## Requirements
- R1: With cfg_word[0]=0 (selector mode) and cfg_word[5]=0 (direct output), pad_drv equals dat_b when sel=1 and dat_a when sel=0, and the inversion bits cfg_word[3] and cfg_word[4] have no effect.
- R2: With cfg_word[0]=1 (gate mode), the stage first inverts dat_a when cfg_word[3]=1 and dat_b when cfg_word[4]=1. Bits cfg_word[2:1] then pick the function: 01 gives AND, 10 gives OR and 11 gives XOR of the two values, lane by lane.
- R3: In gate mode with cfg_word[2:1]=00 (pass), the stage output is dat_a, inverted when cfg_word[3]=1, and dat_b has no effect on pad_drv.
- R4: With cfg_word[5]=1, pad_drv shows the output register. On each active out_clk edge with clk_en=1, that register loads the stage result for that edge.
- R5: cfg_word[7]=1 moves the output register to the falling edge of out_clk. cfg_word[8]=1 moves the input flip-flop to the falling edge of in_clk. When either bit is 0, that element uses the rising edge.
- R6: With cfg_word[6]=1, the input capture element is a latch. It follows pad_in while clk_en=1 and in_clk is at its active level (high when cfg_word[8]=0, low when cfg_word[8]=1), and holds its value otherwise. With cfg_word[6]=0 it is a flip-flop.
- R7: clk_en is active high. While clk_en=0, neither the output register nor the input capture element changes.
- R8: While gsr=1, the output register holds cfg_word[9] and the input capture element holds cfg_word[10] in every lane. gsr acts at once, without waiting for a clock, and overrides clk_en, the clocks and the data.
- R9: With oe_n=1, pad_hiz=1 and pad_obs shows the pull level: all ones when cfg_word[11]=0 (pull-up, the default) and all zeros when cfg_word[11]=1. With oe_n=0, pad_hiz=0 and pad_obs equals pad_drv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_word | input | 12 | Static configuration word (bit meanings in the requirements) |
| gsr | input | 1 | Asynchronous global set/reset, active high |
| out_clk | input | 1 | Output register clock |
| in_clk | input | 1 | Input capture clock or latch gate |
| clk_en | input | 1 | Clock enable shared by both storage elements, active high |
| dat_a | input | W | First output-stage data input |
| dat_b | input | W | Second output-stage data input |
| sel | input | 1 | Selector input for selector mode |
| oe_n | input | 1 | Active-low pad driver enable |
| pad_in | input | W | Data arriving from the pad |
| pad_drv | output | W | Value the pad driver presents |
| pad_hiz | output | 1 | High when the pad driver is off |
| pad_obs | output | W | Level seen on the pad: the driven value, or the pull level when not driven |
| in_q | output | W | Captured input data |

## Verification
The hardest state to reach from the ports is a storage element that is mid-transparency or mid-hold with the clock polarity inverted, just after a set/reset release or a clock-enable drop. It is hard because data, enable and reset all change between edges, and the outcome depends on which half of the clock period they fall in. The stimulus steps through all 4096 configuration words. It changes the word only under set/reset, then runs random data, enable, select and three-state sequences with occasional set/reset pulses. Inputs always change a quarter period after the rising edge, so every change lands in a known phase for each polarity.

// File: rtl/pio_pkg.sv
package pio_pkg;

    // Static configuration word; field order fixes the bit positions.
    typedef struct packed {
        logic       pull_dn;    // [11] 1: pull-down, 0: pull-up
        logic       in_init;    // [10] value of input element under gsr
        logic       out_init;   // [9]  value of output register under gsr
        logic       iclk_fall;  // [8]  input element on falling edge / low level
        logic       oclk_fall;  // [7]  output register on falling edge
        logic       in_latch;   // [6]  1: latch, 0: flip-flop
        logic       out_reg;    // [5]  1: registered output
        logic       inv_b;      // [4]  invert second input (gate mode)
        logic       inv_a;      // [3]  invert first input (gate mode)
        logic [1:0] fn;         // [2:1] 00 pass, 01 and, 10 or, 11 xor
        logic       gate_mode;  // [0]  1: gate, 0: selector
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [1:0] {
        FN_PASS = 2'b00,
        FN_AND  = 2'b01,
        FN_OR   = 2'b10,
        FN_XOR  = 2'b11
    } fn_e;

endpackage

// File: rtl/pio_out_stage.sv
module pio_out_stage
    import pio_pkg::*;
#(
    parameter int W = 1
) (
    input  logic         gate_mode,
    input  logic [1:0]   fn,
    input  logic         inv_a,
    input  logic         inv_b,
    input  logic         sel,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    output logic [W-1:0] y
);

    logic [W-1:0] opa;
    logic [W-1:0] opb;
    logic [W-1:0] gate_y;
    logic [W-1:0] mux_y;

    assign opa   = inv_a ? ~in_a : in_a;
    assign opb   = inv_b ? ~in_b : in_b;
    assign mux_y = sel ? in_b : in_a;

    always_comb begin
        unique case (fn_e'(fn))
            FN_PASS: gate_y = opa;
            FN_AND:  gate_y = opa & opb;
            FN_OR:   gate_y = opa | opb;
            FN_XOR:  gate_y = opa ^ opb;
            default: gate_y = opa;
        endcase
    end

    assign y = gate_mode ? gate_y : mux_y;

endmodule

// File: rtl/pio_edge_reg.sv
module pio_edge_reg #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         fall,
    input  logic         gsr,
    input  logic         init,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    typedef struct packed {
        logic [W-1:0] val;
    } reg_t;

    logic clk_eff;
    reg_t st_d;
    reg_t st_q;

    assign clk_eff = clk ^ fall;

    always_comb begin
        st_d = st_q;
        if (ce) begin
            st_d.val = d;
        end
    end

    always_ff @(posedge clk_eff or posedge gsr) begin
        if (gsr) begin
            st_q.val <= {W{init}};
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;

endmodule

// File: rtl/pio_in_capture.sv
module pio_in_capture #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         fall,
    input  logic         latch_mode,
    input  logic         gsr,
    input  logic         init,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] ff_q;
    logic [W-1:0] lat_q;
    logic         open_lvl;

    pio_edge_reg #(.W(W)) u_ff (
        .clk  (clk),
        .fall (fall),
        .gsr  (gsr),
        .init (init),
        .ce   (ce),
        .d    (d),
        .q    (ff_q)
    );

    // Latch is open at the active level of its gate.
    assign open_lvl = (clk ^ fall) & ce;

    always_latch begin
        if (gsr) begin
            lat_q = {W{init}};
        end else if (open_lvl) begin
            lat_q = d;
        end
    end

    assign q = latch_mode ? lat_q : ff_q;

endmodule

// File: rtl/pio_cell.sv
module pio_cell
    import pio_pkg::*;
#(
    parameter int W = 1
) (
    input  logic [11:0]  cfg_word,
    input  logic         gsr,
    input  logic         out_clk,
    input  logic         in_clk,
    input  logic         clk_en,
    input  logic [W-1:0] dat_a,
    input  logic [W-1:0] dat_b,
    input  logic         sel,
    input  logic         oe_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_drv,
    output logic         pad_hiz,
    output logic [W-1:0] pad_obs,
    output logic [W-1:0] in_q
);

    cfg_t         cfg;
    logic [W-1:0] stage_y;
    logic [W-1:0] oreg_q;
    logic [W-1:0] pull_lvl;

    assign cfg      = cfg_t'(cfg_word);
    assign pull_lvl = {W{~cfg.pull_dn}};

    pio_out_stage #(.W(W)) u_stage (
        .gate_mode (cfg.gate_mode),
        .fn        (cfg.fn),
        .inv_a     (cfg.inv_a),
        .inv_b     (cfg.inv_b),
        .sel       (sel),
        .in_a      (dat_a),
        .in_b      (dat_b),
        .y         (stage_y)
    );

    pio_edge_reg #(.W(W)) u_oreg (
        .clk  (out_clk),
        .fall (cfg.oclk_fall),
        .gsr  (gsr),
        .init (cfg.out_init),
        .ce   (clk_en),
        .d    (stage_y),
        .q    (oreg_q)
    );

    pio_in_capture #(.W(W)) u_icap (
        .clk        (in_clk),
        .fall       (cfg.iclk_fall),
        .latch_mode (cfg.in_latch),
        .gsr        (gsr),
        .init       (cfg.in_init),
        .ce         (clk_en),
        .d          (pad_in),
        .q          (in_q)
    );

    assign pad_drv = cfg.out_reg ? oreg_q : stage_y;
    assign pad_hiz = oe_n;
    assign pad_obs = oe_n ? pull_lvl : pad_drv;

endmodule

// File: rtl/pio_cell_chk.sv
module pio_cell_chk #(
    parameter int W = 1
) (
    input logic [11:0]  cfg_word,
    input logic         gsr,
    input logic         out_clk,
    input logic         clk_en,
    input logic [W-1:0] dat_a,
    input logic [W-1:0] dat_b,
    input logic         sel,
    input logic         oe_n,
    input logic [W-1:0] pad_drv,
    input logic         pad_hiz,
    input logic [W-1:0] pad_obs,
    input logic [W-1:0] in_q
);

    AST_HIZ_PULL: assert property (@(posedge out_clk) disable iff (gsr)
        oe_n |-> (pad_hiz && pad_obs == {W{~cfg_word[11]}})); // R9

    AST_DRIVE_OBS: assert property (@(posedge out_clk) disable iff (gsr)
        !oe_n |-> (!pad_hiz && pad_obs == pad_drv)); // R9

    AST_SELECT_DIRECT: assert property (@(posedge out_clk) disable iff (gsr)
        (!cfg_word[0] && !cfg_word[5]) |-> (pad_drv == (sel ? dat_b : dat_a))); // R1

    AST_PASS_FIRST: assert property (@(posedge out_clk) disable iff (gsr)
        (cfg_word[0] && cfg_word[2:1] == 2'b00 && !cfg_word[5])
        |-> (pad_drv == (cfg_word[3] ? ~dat_a : dat_a))); // R3

    AST_HOLD_NO_CE: assert property (@(posedge out_clk) disable iff (gsr)
        (cfg_word[5] && !cfg_word[7] && !clk_en) |=> $stable(pad_drv)); // R7

    always @(negedge out_clk) begin
        if (gsr) begin
            AST_GSR_INPUT: assert (in_q == {W{cfg_word[10]}}); // R8
            if (cfg_word[5]) begin
                AST_GSR_OUTPUT: assert (pad_drv == {W{cfg_word[9]}}); // R8
            end
        end
    end

endmodule

bind pio_cell pio_cell_chk #(.W(W)) u_pio_cell_chk (
    .cfg_word (cfg_word),
    .gsr      (gsr),
    .out_clk  (out_clk),
    .clk_en   (clk_en),
    .dat_a    (dat_a),
    .dat_b    (dat_b),
    .sel      (sel),
    .oe_n     (oe_n),
    .pad_drv  (pad_drv),
    .pad_hiz  (pad_hiz),
    .pad_obs  (pad_obs),
    .in_q     (in_q)
);

// File: tb/pio_cell_bench.sv
`timescale 1ns/1ps
module pio_cell_bench;

    localparam int W = 2;
    localparam int CYC_PER_CFG = 16;

    logic [11:0]  cfg_word = '0;
    logic         gsr = 1'b1;
    logic         clk = 1'b0;
    logic         clk_en = 1'b0;
    logic [W-1:0] dat_a = '0;
    logic [W-1:0] dat_b = '0;
    logic         sel = 1'b0;
    logic         oe_n = 1'b1;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_drv;
    logic         pad_hiz;
    logic [W-1:0] pad_obs;
    logic [W-1:0] in_q;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    pio_cell #(.W(W)) u_pio_cell (
        .cfg_word (cfg_word),
        .gsr      (gsr),
        .out_clk  (clk),
        .in_clk   (clk),
        .clk_en   (clk_en),
        .dat_a    (dat_a),
        .dat_b    (dat_b),
        .sel      (sel),
        .oe_n     (oe_n),
        .pad_in   (pad_in),
        .pad_drv  (pad_drv),
        .pad_hiz  (pad_hiz),
        .pad_obs  (pad_obs),
        .in_q     (in_q)
    );

    // Reference state and inputs seen at the previous rising edge
    logic [W-1:0] m_oq, m_iq;
    logic [11:0]  p_cfg = '0;
    logic         p_gsr = 1'b1, p_ce = 1'b0, p_sel = 1'b0;
    logic [W-1:0] p_a = '0, p_b = '0, p_pin = '0;

    function automatic logic [W-1:0] ref_stage(input logic [11:0] c,
                                               input logic [W-1:0] a, b,
                                               input logic s);
        logic [W-1:0] x, y;
        if (!c[0]) return s ? b : a;
        x = c[3] ? ~a : a;
        y = c[4] ? ~b : b;
        case (c[2:1])
            2'd0:    return x;
            2'd1:    return x & y;
            2'd2:    return x | y;
            default: return x ^ y;
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cfg=%h actual=%b expected=%b at %0t", tag, cfg_word, act, exp, $time);
        end
    endtask

    // Called a quarter period after a rising edge.
    task automatic step(input logic [11:0] c, input logic g, input logic e,
                        input logic s, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] pin, input logic oe);
        string t_out, t_in;
        logic [W-1:0] exp_drv;
        // effect of the rising edge just passed
        if (p_gsr) begin
            m_oq = {W{p_cfg[9]}};
            m_iq = {W{p_cfg[10]}};
        end else begin
            if (!p_cfg[7] && p_ce) m_oq = ref_stage(p_cfg, p_a, p_b, p_sel);
            if (!p_cfg[8] && p_ce) m_iq = p_pin;   // rising flip-flop, or latch opened high
        end
        gsr = g;
        cfg_word = c;
        clk_en = e; sel = s; dat_a = a; dat_b = b; pad_in = pin; oe_n = oe;
        if (g) begin
            m_oq = {W{c[9]}};
            m_iq = {W{c[10]}};
        end
        p_cfg = c; p_gsr = g; p_ce = e; p_sel = s; p_a = a; p_b = b; p_pin = pin;
        #2;
        // falling edge passed; latches have seen the current pad value
        if (!g && e) begin
            if (c[7]) m_oq = ref_stage(c, a, b, s);
            if (c[8] || c[6]) m_iq = pin;
        end
        exp_drv = c[5] ? m_oq : ref_stage(c, a, b, s);
        if (g && c[5])        t_out = "R8";
        else if (c[5] && !e)  t_out = "R7";
        else if (c[5])        t_out = c[7] ? "R5" : "R4";
        else if (!c[0])       t_out = "R1";
        else if (c[2:1] == 0) t_out = "R3";
        else                  t_out = "R2";
        if (g)          t_in = "R8";
        else if (!e)    t_in = "R7";
        else if (c[6])  t_in = "R6";
        else            t_in = "R5";
        check(t_out, pad_drv, exp_drv);
        check(t_in, in_q, m_iq);
        check("R9", {{(W-1){1'b0}}, pad_hiz}, {{(W-1){1'b0}}, oe});
        check("R9", pad_obs, oe ? {W{~c[11]}} : exp_drv);
        #2;
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_oq = '0;
        m_iq = '0;
        #3;
        for (int c = 0; c < 4096; c++) begin
            step(c[11:0], 1'b1, 1'b1, 1'b0, W'($urandom), W'($urandom), W'($urandom), 1'b1);
            for (int k = 1; k < CYC_PER_CFG; k++) begin
                step(c[11:0], ($urandom % 24) == 0, ($urandom % 4) != 0, 1'($urandom),
                     W'($urandom), W'($urandom), W'($urandom), ($urandom % 3) == 0);
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule